// File: doc/BRIEF.md
# Serial Transmitter with Flow Control

This block is the send half of a programmable serial port. A CPU writes a character into a one-entry holding register. The block moves that character into a frame shift register and sends it least-significant bit first on `txd`.

- **Asynchronous mode:** every character gets a start bit, an optional parity bit and one or two stop bits. Each bit lasts 1, 16 or 64 cycles of the transmit clock.
- **Synchronous mode:** bare characters go out at one bit per transmit clock. When nothing is waiting, a programmed filler character is sent in place of data.

The line changes only on falling edges of the transmit clock. `txClk` is sampled by the system clock through two flops.

Sending is permitted only when the enable command bit is set and the active-low clear-to-send input is low. Once a character has been accepted, removing that permission does not cut it off: every character already queued is sent before the line goes back to idle.

The block reports three things:
- whether the holding register can take a character, on a status output and on a pin output masked by the enable bit;
- whether the transmitter has nothing left to send;
- the request-to-send output, which is the inverse of its command bit.

Top module: `serTx`

## Requirements
- R1: After reset, with `txEnable` low, `txd` is 1, `txRdyStatus` is 1, `txRdyPin` is 0 and `txEmpty` is 1.
- R2: An asynchronous frame is sent in this order:
  - a start bit of 0;
  - N data bits, least-significant bit first, where N is 5, 6, 7 or 8 for `charLen` 0, 1, 2 or 3;
  - when `parityEn` is 1, one parity bit that makes the count of ones in data plus parity even (`parityOdd`=0) or odd (`parityOdd`=1);
  - one stop bit of 1, or two when `stopTwo` is 1.
- R3: In asynchronous mode each bit lasts 1, 16 or 64 `txClk` periods for `factorSel` 0, 1 or 2 (3 behaves as 2). In synchronous mode each bit lasts one `txClk` period whatever `factorSel` is.
- R4: `txd` changes only on the `clk` edge that follows the one where a 1-to-0 step of `txClk` is seen at the output of its two-flop synchronizer.
- R5: In asynchronous mode `txd` rests at 1 whenever the transmitter has nothing it may send, including while disabled or while `ctsN` is high before a character starts.
- R6: A character in the holding register starts only while `txEnable` is 1 and `ctsN` is 0.
- R7: When `txEnable` falls or `ctsN` rises after a character has started, that character and any character already in the holding register are both sent, back to back with no idle bit between frames, and then the line goes idle.
- R8: A `wrData` pulse makes `txRdyStatus` 0 until the character moves to the shift register. `txRdyStatus` reflects only whether the holding register is empty. `txRdyPin` equals `txRdyStatus` AND `txEnable`.
- R9: `txEmpty` is 0 only while a data character is held or being shifted and sending is permitted or still draining. A character written while sending is not permitted leaves `txEmpty` at 1.
- R10: In synchronous mode (`modeSync`=1), with sending permitted and no character held, frames of `syncChar` are sent back to back and `txEmpty` stays 1. A written data character is sent between two fillers, at a frame boundary.
- R11: `rtsN` is the inverse of `rtsCmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high master reset |
| txClk | input | 1 | Transmit clock; its falling edges pace the line |
| wrData | input | 1 | One-cycle pulse that writes `wrByte` into the holding register |
| wrByte | input | 8 | Character written by the CPU |
| modeSync | input | 1 | 1 selects synchronous mode |
| factorSel | input | 2 | Asynchronous clock factor: 0 for 1x, 1 for 16x, 2 or 3 for 64x |
| charLen | input | 2 | Character length minus 5 |
| parityEn | input | 1 | Adds a parity bit after the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| stopTwo | input | 1 | 1 selects two stop bits |
| syncChar | input | 8 | Filler character for synchronous mode |
| txEnable | input | 1 | Transmit enable command bit |
| ctsN | input | 1 | Active-low clear to send |
| rtsCmd | input | 1 | Request-to-send command bit |
| txd | output | 1 | Serial data line |
| txRdyPin | output | 1 | Holding register empty, masked by `txEnable` |
| txRdyStatus | output | 1 | Holding register empty, unmasked |
| txEmpty | output | 1 | Nothing left to send |
| rtsN | output | 1 | Inverted request-to-send |

## Verification
The bench covers every character length against every parity setting and both stop counts at the 1x factor, then checks the 16x and 64x factors.
- A bit-order or parity mistake would decode to the wrong frame value.
- A divider off by one would shift the mid-bit sample points out of their bits.

The harder cases are flow-control changes while a character is in flight. Dropping enable, or raising clear-to-send, while one character is shifting and a second is held must still deliver both frames, back to back. A design that gates the load with the live enable would lose the second frame. A design that gates the shifter would stop mid-frame.

The bench also checks three other cases:
- A character written while disabled stays off the line and leaves the empty flag high.
- The synchronous filler must hold the empty flag high.
- The data character must replace exactly one filler frame at a frame boundary.

// File: rtl/serTxPkg.sv
package serTxPkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic loadData;
    logic loadSync;
    logic shift;
    logic goIdle;
  } txStrobeT;

  // Frame image, bit 0 first on the line; unused upper bits stay 1
  function automatic logic [FRAME_W-1:0] buildFrame(
    input logic [DATA_W-1:0] d,
    input logic [1:0]        lenSel,
    input logic              parEn,
    input logic              parOdd,
    input logic              syncMode
  );
    logic [FRAME_W-1:0] f;
    int n;
    int pos;
    logic p;
    f   = '1;
    n   = 5 + int'(lenSel);
    pos = syncMode ? 0 : 1;
    if (!syncMode) f[0] = 1'b0;
    p = parOdd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        f[pos+i] = d[i];
        p = p ^ d[i];
      end
    end
    if (parEn) f[pos+n] = p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frameLen(
    input logic [1:0] lenSel,
    input logic       parEn,
    input logic       stopTwo,
    input logic       syncMode
  );
    logic [LEN_W-1:0] l;
    l = LEN_W'(5) + LEN_W'(lenSel) + LEN_W'(parEn);
    if (!syncMode) l = l + LEN_W'(1) + (stopTwo ? LEN_W'(2) : LEN_W'(1));
    return l;
  endfunction
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fallStb,
  input  logic       modeSync,
  input  logic [1:0] factorSel,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       stopTwo,
  input  logic       txEnable,
  input  logic       ctsN,
  input  logic       holdFull,
  output txStrobeT   strb,
  output logic       busyData,
  output logic       gate
);
  logic             busy;
  logic             armed;
  logic [DIV_W-1:0] divCnt;
  logic [LEN_W-1:0] bitsLeft;
  logic [DIV_W-1:0] divMax;
  logic             permit;
  logic             divEnd;
  logic             lastBit;
  logic             canStart;

  assign permit = txEnable & ~ctsN;
  assign gate   = permit | armed;

  always_comb begin
    if (modeSync || factorSel == 2'd0) divMax = '0;
    else if (factorSel == 2'd1)        divMax = DIV_W'(15);
    else                               divMax = DIV_W'(63);
  end

  assign divEnd   = busy & (divCnt == divMax);
  assign lastBit  = divEnd & (bitsLeft == LEN_W'(1));
  assign canStart = fallStb & (~busy | lastBit);

  always_comb begin
    strb          = '0;
    strb.loadData = canStart & holdFull & gate;
    strb.loadSync = canStart & ~strb.loadData & modeSync & permit;
    strb.shift    = fallStb & divEnd & ~lastBit;
    strb.goIdle   = fallStb & lastBit & ~strb.loadData & ~strb.loadSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      busyData <= 1'b0;
      armed    <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else begin
      armed <= permit | (armed & (holdFull | busyData));
      if (strb.loadData || strb.loadSync) begin
        busy     <= 1'b1;
        busyData <= strb.loadData;
        divCnt   <= '0;
        bitsLeft <= frameLen(charLen, parityEn, stopTwo, modeSync);
      end else if (strb.shift) begin
        divCnt   <= '0;
        bitsLeft <= bitsLeft - LEN_W'(1);
      end else if (strb.goIdle) begin
        busy     <= 1'b0;
        busyData <= 1'b0;
      end else if (fallStb && busy) begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/serTxPath.sv
module serTxPath
  import serTxPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  txStrobeT          strb,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [DATA_W-1:0] syncChar,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              modeSync,
  output logic              holdFull,
  output logic              txd
);
  logic [DATA_W-1:0]  hold;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frm;

  assign frm = buildFrame(strb.loadSync ? syncChar : hold, charLen, parityEn,
                          parityOdd, modeSync);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      holdFull <= 1'b0;
      shiftReg <= '1;
      txd      <= 1'b1;
    end else begin
      if (strb.loadData) holdFull <= 1'b0;
      if (wrData) begin
        hold     <= wrByte;
        holdFull <= 1'b1;
      end
      if (strb.loadData || strb.loadSync) begin
        txd      <= frm[0];
        shiftReg <= {1'b1, frm[FRAME_W-1:1]};
      end else if (strb.shift) begin
        txd      <= shiftReg[0];
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      end else if (strb.goIdle) begin
        txd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serTx.sv
module serTx
  import serTxPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              txClk,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              modeSync,
  input  logic [1:0]        factorSel,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              stopTwo,
  input  logic [DATA_W-1:0] syncChar,
  input  logic              txEnable,
  input  logic              ctsN,
  input  logic              rtsCmd,
  output logic              txd,
  output logic              txRdyPin,
  output logic              txRdyStatus,
  output logic              txEmpty,
  output logic              rtsN
);
  logic     clkQ1;
  logic     clkQ2;
  logic     fallStb;
  txStrobeT strb;
  logic     holdFull;
  logic     busyData;
  logic     gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkQ1 <= 1'b0;
      clkQ2 <= 1'b0;
    end else begin
      clkQ1 <= txClk;
      clkQ2 <= clkQ1;
    end
  end
  assign fallStb = clkQ2 & ~clkQ1;

  serTxCtrl #(.DIV_W(6)) u_ctrl (
    .clk(clk), .rst(rst), .fallStb(fallStb), .modeSync(modeSync),
    .factorSel(factorSel), .charLen(charLen), .parityEn(parityEn),
    .stopTwo(stopTwo), .txEnable(txEnable), .ctsN(ctsN), .holdFull(holdFull),
    .strb(strb), .busyData(busyData), .gate(gate)
  );

  serTxPath u_path (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .wrByte(wrByte),
    .syncChar(syncChar), .charLen(charLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .modeSync(modeSync), .holdFull(holdFull), .txd(txd)
  );

  assign txRdyStatus = ~holdFull;
  assign txRdyPin    = ~holdFull & txEnable;
  assign txEmpty     = ~((holdFull | busyData) & gate);
  assign rtsN        = ~rtsCmd;
endmodule

// File: rtl/serTxChecker.sv
module serTxChecker (
  input logic       clk,
  input logic       rst,
  input logic       txClk,
  input logic       wrData,
  input logic [7:0] wrByte,
  input logic       modeSync,
  input logic [1:0] factorSel,
  input logic [1:0] charLen,
  input logic       parityEn,
  input logic       parityOdd,
  input logic       stopTwo,
  input logic [7:0] syncChar,
  input logic       txEnable,
  input logic       ctsN,
  input logic       rtsCmd,
  input logic       txd,
  input logic       txRdyPin,
  input logic       txRdyStatus,
  input logic       txEmpty,
  input logic       rtsN
);
  logic seen1;
  logic seen2;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= txClk;
      seen2 <= seen1;
    end
  end

  assert_txd_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (txd != $past(txd)) |-> $past(seen2 & ~seen1));

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (rst)
    wrData |=> !txRdyStatus);

  assert_pin_masked_R8: assert property (@(posedge clk) disable iff (rst)
    txRdyPin |-> (txEnable && txRdyStatus));

  assert_idle_mark_R5: assert property (@(posedge clk) disable iff (rst)
    (txEmpty && !modeSync) |-> txd);

  assert_held_not_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (!txRdyStatus && txEnable && !ctsN) |-> !txEmpty);
endmodule

bind serTx serTxChecker u_chk (.*);

// File: tb/serTx_bench.sv
module serTx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txClk = 1'b1;
  logic       wrData = 1'b0;
  logic [7:0] wrByte = '0;
  logic       modeSync = 1'b0;
  logic [1:0] factorSel = 2'd0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       stopTwo = 1'b0;
  logic [7:0] syncChar = 8'h96;
  logic       txEnable = 1'b0;
  logic       ctsN = 1'b0;
  logic       rtsCmd = 1'b0;
  logic       txd, txRdyPin, txRdyStatus, txEmpty, rtsN;

  int checks = 0;
  int failures = 0;
  int phase = 0;
  logic capBit [16384];
  int   capN = 0;
  logic capOn = 1'b0;

  serTx u_serTx (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    phase <= (phase + 1) % 4;
    txClk <= (phase < 2);
  end

  always @(negedge clk) begin
    if (!capOn) capN = 0;
    else if (capN < 16384) begin
      capBit[capN] = txd;
      capN = capN + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] b);
    @(negedge clk);
    wrData = 1'b1;
    wrByte = b;
    @(negedge clk);
    wrData = 1'b0;
  endtask

  // Expected async frame, bit 0 first
  task automatic expAsync(input int d, input int n, input bit pe, input bit odd,
                          input bit two, output int val, output int len);
    int masked, ones, pos;
    masked = d & ((1 << n) - 1);
    ones = $countones(masked);
    val = masked << 1;
    pos = n + 1;
    if (pe) begin
      val = val | ((((ones % 2) ^ odd) & 1) << pos);
      pos++;
    end
    val = val | ((two ? 3 : 1) << pos);
    len = pos + (two ? 2 : 1);
  endtask

  task automatic decodeFrame(input int from, input int spb, input int expVal,
                             input int expLen, input string req, output int nextIdx);
    int st, got, idx;
    st = -1;
    for (int i = from; i < capN; i++) begin
      if (capBit[i] == 1'b0) begin
        st = i;
        break;
      end
    end
    got = 0;
    if (st >= 0) begin
      for (int k = 0; k < expLen; k++) begin
        idx = st + k * spb + spb / 2;
        if (idx < capN && capBit[idx]) got = got | (1 << k);
      end
    end
    chk(st >= 0 && got == expVal, req, got, expVal);
    nextIdx = (st < 0) ? capN : st + expLen * spb;
  endtask

  task automatic countZeros(input int from, output int z);
    z = 0;
    for (int i = from; i < capN; i++) if (capBit[i] == 1'b0) z++;
  endtask

  task automatic asyncOne(input logic [7:0] d, input int f, input string req);
    int v, l, nx;
    capOn = 1'b1;
    waitClk(3);
    writeChar(d);
    waitClk(3);
    chk(txEmpty == 1'b0, "R9 empty low while sending", txEmpty, 0);
    expAsync(d, 5 + charLen, parityEn, parityOdd, stopTwo, v, l);
    waitClk(l * 4 * f + 20);
    decodeFrame(0, 4 * f, v, l, req, nx);
    chk(txEmpty == 1'b1 && txd == 1'b1, "R5 idle mark after frame", {txEmpty, txd}, 3);
    capOn = 1'b0;
    waitClk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, l, nx, nx2, z, st, chunk, cnt, idx;
    bit foundData;
    waitClk(5);
    rst = 1'b0;
    waitClk(3);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(txRdyStatus == 1'b1, "R1 txRdyStatus", txRdyStatus, 1);
    chk(txRdyPin == 1'b0, "R1 txRdyPin", txRdyPin, 0);
    chk(txEmpty == 1'b1, "R1 txEmpty", txEmpty, 1);

    // R11 request to send
    rtsCmd = 1'b1;
    waitClk(1);
    chk(rtsN == 1'b0, "R11 rtsN set", rtsN, 0);
    rtsCmd = 1'b0;
    waitClk(1);
    chk(rtsN == 1'b1, "R11 rtsN clear", rtsN, 1);

    // R6 R8 R9 write while disabled, then with CTS high, then permitted
    capOn = 1'b1;
    writeChar(8'h5A);
    waitClk(2);
    chk(txRdyStatus == 1'b0, "R8 status clears on write", txRdyStatus, 0);
    chk(txEmpty == 1'b1, "R9 empty stays high while disabled", txEmpty, 1);
    txEnable = 1'b1;
    ctsN = 1'b1;
    waitClk(2);
    chk(txRdyPin == 1'b0, "R8 pin low while held", txRdyPin, 0);
    waitClk(100);
    countZeros(0, z);
    chk(z == 0, "R6 no start while disabled or cts high", z, 0);
    chk(txEmpty == 1'b1, "R9 empty high with cts high", txEmpty, 1);
    capOn = 1'b0;
    waitClk(1);
    capOn = 1'b1;
    ctsN = 1'b0;
    expAsync(8'h5A, 8, 0, 0, 0, v, l);
    waitClk(l * 4 + 20);
    decodeFrame(0, 4, v, l, "R6 frame after permission", nx);
    chk(txRdyStatus == 1'b1 && txRdyPin == 1'b1, "R8 ready after load",
        {txRdyStatus, txRdyPin}, 3);
    capOn = 1'b0;
    waitClk(2);

    // R2 sweep: length x parity x stop at 1x
    factorSel = 2'd0;
    for (int ln = 0; ln < 4; ln++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int sb = 0; sb < 2; sb++) begin
          charLen = 2'(ln);
          parityEn = (pm != 0);
          parityOdd = (pm == 2);
          stopTwo = sb[0];
          asyncOne(8'(8'hA5 ^ (ln * 37 + pm * 11 + sb * 5)), 1, "R2 async frame");
        end
      end
    end

    // R3 clock factors
    charLen = 2'd3; parityEn = 1'b1; parityOdd = 1'b0; stopTwo = 1'b0;
    factorSel = 2'd1;
    asyncOne(8'hC3, 16, "R3 16x frame");
    factorSel = 2'd2;
    asyncOne(8'h31, 64, "R3 64x frame");

    // R7 drain after enable drops, 16x
    factorSel = 2'd1; parityEn = 1'b0;
    capOn = 1'b1;
    waitClk(3);
    writeChar(8'h81);
    waitClk(10);
    writeChar(8'h7E);
    waitClk(2);
    txEnable = 1'b0;
    waitClk(1);
    chk(txRdyPin == 1'b0, "R8 pin masked by enable", txRdyPin, 0);
    expAsync(8'h81, 8, 0, 0, 0, v, l);
    waitClk(2 * l * 64 + 60);
    decodeFrame(0, 64, v, l, "R7 first frame drains", nx);
    expAsync(8'h7E, 8, 0, 0, 0, v, l);
    chk(capBit[nx + 32] == 1'b0, "R7 second start follows stop", capBit[nx + 32], 0);
    decodeFrame(nx, 64, v, l, "R7 second frame drains", nx2);
    chk(txEmpty == 1'b1 && txd == 1'b1, "R9 empty after drain", {txEmpty, txd}, 3);
    capOn = 1'b0;
    waitClk(2);

    // R7 drain after cts rises, 1x
    factorSel = 2'd0;
    txEnable = 1'b1;
    capOn = 1'b1;
    waitClk(3);
    writeChar(8'h0F);
    waitClk(8);
    writeChar(8'hF0);
    waitClk(2);
    ctsN = 1'b1;
    expAsync(8'h0F, 8, 0, 0, 0, v, l);
    waitClk(2 * l * 4 + 30);
    decodeFrame(0, 4, v, l, "R7 cts first frame", nx);
    expAsync(8'hF0, 8, 0, 0, 0, v, l);
    decodeFrame(nx, 4, v, l, "R7 cts second frame", nx2);
    writeChar(8'h55);
    waitClk(60);
    countZeros(nx2, z);
    chk(z == 0, "R6 held while cts high", z, 0);
    chk(txEmpty == 1'b1, "R9 empty with blocked char", txEmpty, 1);
    ctsN = 1'b0;
    expAsync(8'h55, 8, 0, 0, 0, v, l);
    waitClk(l * 4 + 20);
    decodeFrame(nx2, 4, v, l, "R6 released frame", nx);
    capOn = 1'b0;
    waitClk(2);

    // R10 synchronous filler, factorSel ignored (R3)
    txEnable = 1'b0;
    waitClk(4);
    modeSync = 1'b1; factorSel = 2'd2; charLen = 2'd3; parityEn = 1'b0;
    capOn = 1'b1;
    waitClk(3);
    txEnable = 1'b1;
    waitClk(100);
    chk(txEmpty == 1'b1, "R10 empty high during fillers", txEmpty, 1);
    chk(txRdyStatus == 1'b1, "R10 status during fillers", txRdyStatus, 1);
    writeChar(8'h3C);
    waitClk(160);
    st = -1;
    for (int i = 0; i < capN; i++) begin
      if (capBit[i] == 1'b0) begin
        st = i;
        break;
      end
    end
    foundData = 1'b0;
    cnt = 0;
    for (int c = 0; c < 12; c++) begin
      chunk = 0;
      for (int k = 0; k < 8; k++) begin
        idx = st + (c * 8 + k) * 4 + 2;
        if (idx < capN && capBit[idx]) chunk = chunk | (1 << k);
      end
      if (c == 0) chk(chunk == 8'h96, "R10 first filler", chunk, 8'h96);
      if (!foundData && chunk != 8'h96) begin
        foundData = 1'b1;
        chk(chunk == 8'h3C, "R10 data between fillers", chunk, 8'h3C);
        cnt = c + 1;
      end
    end
    chunk = 0;
    for (int k = 0; k < 8; k++) begin
      idx = st + (cnt * 8 + k) * 4 + 2;
      if (idx < capN && capBit[idx]) chunk = chunk | (1 << k);
    end
    chk(foundData && chunk == 8'h96, "R10 filler resumes", chunk, 8'h96);
    chk(txEmpty == 1'b1, "R10 empty after data", txEmpty, 1);
    txEnable = 1'b0;
    waitClk(80);
    chk(txd == 1'b1, "R5 mark after sync disable", txd, 1);
    capOn = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule